// File: doc/BRIEF.md
# CAN Interrupt Flag Aggregator

This block collects the event sources of a mailbox-based CAN controller core and folds them into two interrupt lines, line 0 and line 1. For each line it holds a 32-bit global flag word and a mailbox interrupt vector. Per-mailbox status comes in as level vectors: transfer done, timeout, abort acknowledged and receive lost. Each mailbox is steered to one line by its own level bit, and its transfer-done bit counts only while its mask bit is set. Controller-wide events (error warning, error passive, bus-off, wake-up, denied identifier write, timestamp MSB rising) are steered as a group by one global level bit.

The vector field names the mailbox that caused the mailbox flag. Higher mailbox numbers have higher priority. The field holds its value until the flag drops or a higher-numbered mailbox raises an event. A compatibility mode reduces the view to the lower 16 mailboxes.

Flags that mirror per-mailbox status clear themselves when the core clears that status. Flags for controller events are sticky and are cleared by software with a write-1-to-clear strobe aimed at one line. All status and control pins are plain levels. No data stream crosses the block, so it has no valid/ready handshake.

Top module: `can_irq_agg`

## Requirements
- R1: The mailbox flag (bit 15) of a line is set one clock after some mailbox routed to that line has both its done bit and its mask bit set. It drops one clock after no such mailbox remains.
- R2: A mailbox goes to line 1 when its level bit is 1 and to line 0 when it is 0. The done, timeout (bit 17), abort (bit 14) and receive-lost (bit 11) flags all follow this routing.
- R3: When the mailbox flag rises, the vector (bits 4:0) holds the highest-numbered pending mailbox. While the flag stays set, the vector moves only to a pending mailbox with a higher number.
- R4: If the mailbox named by the vector stops pending while others still pend, the vector keeps its value. One clock after nothing pends on the line, both the vector and the mailbox flag read 0.
- R5: With compatibility mode at 1, mailboxes 16 to 31 are ignored for every per-mailbox flag and the timeout flag reads 0. The vector then stays below 16, and a stale higher value is replaced by the highest pending mailbox.
- R6: The timestamp overflow flag (bit 16) is set one clock after the timestamp MSB input goes from 0 to 1. A level that stays high does not set it again.
- R7: The timeout, abort and receive-lost flags follow their routed status bits one clock later. A write-1-to-clear has no effect on them.
- R8: The warning (bit 8), error-passive (bit 9), bus-off (bit 10), wake-up (bit 12), write-denied (bit 13) and timestamp flags are set on the line chosen by the global level bit, and they hold their value. A clear strobe clears the bits whose mask bits are 1, only on the line that the strobe selects. Mask bits of 0 leave flags unchanged. A set in the same clock as a clear wins.
- R9: Bits 31:18 and 7:5 of both flag words always read 0, including after a clear strobe with all mask bits at 1.
- R10: Each interrupt line is 1 exactly when any of bits 17:8 of its flag word is 1.
- R11: After reset, both flag words are 0 and both interrupt lines are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| compat_mode | input | 1 | 1 = only mailboxes 0 to 15 are seen |
| mbx_done | input | NUM_MBX | Per-mailbox transfer-done status |
| mbx_tmo | input | NUM_MBX | Per-mailbox timeout status |
| mbx_abort | input | NUM_MBX | Per-mailbox abort-acknowledge status |
| mbx_lost | input | NUM_MBX | Per-mailbox receive-lost status |
| mbx_mask | input | NUM_MBX | Per-mailbox enable for the done event |
| mbx_lvl | input | NUM_MBX | Per-mailbox line select (1 = line 1) |
| glb_lvl | input | 1 | Line select for controller events (1 = line 1) |
| ev_warn | input | 1 | Error-warning event pulse |
| ev_epass | input | 1 | Error-passive event pulse |
| ev_busoff | input | 1 | Bus-off event pulse |
| ev_wake | input | 1 | Wake-up event pulse |
| ev_wrdeny | input | 1 | Denied identifier write event pulse |
| ts_msb | input | 1 | Timestamp counter MSB |
| clr_we | input | 1 | Clear strobe |
| clr_line | input | 1 | Line that the clear strobe selects |
| clr_mask | input | 32 | Write-1-to-clear mask, same bit layout as the flag word |
| flags0 | output | 32 | Line 0 flag word |
| flags1 | output | 32 | Line 1 flag word |
| irq0 | output | 1 | Line 0 interrupt |
| irq1 | output | 1 | Line 1 interrupt |

## Verification
The bench builds the block with its default parameters: 32 mailboxes and a 16-mailbox compatibility window. This lets it reach mailbox 31 as the top priority and the 15/16 boundary where compatibility mode cuts off. Random traffic switches compatibility mode while the vector is stale and above 15, which exercises the reselection rule. Directed sequences hold the vector through lower-numbered arrivals and departures, and they make a set and a clear collide in the same clock.

// File: rtl/can_irq_pkg.sv
package can_irq_pkg;
  localparam int FLAG_W   = 32;
  localparam int B_TMO    = 17;
  localparam int B_TSOVF  = 16;
  localparam int B_GMIF   = 15;
  localparam int B_ABORT  = 14;
  localparam int B_WRDENY = 13;
  localparam int B_WAKE   = 12;
  localparam int B_LOST   = 11;
  localparam int B_BUSOFF = 10;
  localparam int B_EPASS  = 9;
  localparam int B_WARN   = 8;
  localparam int N_EVT    = 6;
  // sticky bank order, index 0 first
  typedef enum int {
    E_WARN = 0, E_EPASS = 1, E_BUSOFF = 2, E_WAKE = 3, E_WRDENY = 4, E_TSOVF = 5
  } evt_idx_e;
endpackage

// File: rtl/can_irq_route.sv
module can_irq_route #(
  parameter int NUM_MBX  = 32,
  parameter int COMPAT_N = 16,
  parameter bit LINE     = 1'b0
) (
  input  logic [NUM_MBX-1:0] mbx_done,
  input  logic [NUM_MBX-1:0] mbx_tmo,
  input  logic [NUM_MBX-1:0] mbx_abort,
  input  logic [NUM_MBX-1:0] mbx_lost,
  input  logic [NUM_MBX-1:0] mbx_mask,
  input  logic [NUM_MBX-1:0] mbx_lvl,
  input  logic               compat_mode,
  output logic [NUM_MBX-1:0] pend,
  output logic               tmo_any,
  output logic               abort_any,
  output logic               lost_any
);
  logic [NUM_MBX-1:0] keep;
  logic [NUM_MBX-1:0] mine;

  always_comb begin
    for (int i = 0; i < NUM_MBX; i++) begin
      keep[i] = !compat_mode || (i < COMPAT_N);
    end
  end

  assign mine      = (LINE ? mbx_lvl : ~mbx_lvl) & keep;
  assign pend      = mbx_done & mbx_mask & mine;
  assign tmo_any   = !compat_mode && (|(mbx_tmo & mine));
  assign abort_any = |(mbx_abort & mine);
  assign lost_any  = |(mbx_lost & mine);
endmodule

// File: rtl/can_irq_vec.sv
module can_irq_vec #(
  parameter int NUM_MBX  = 32,
  parameter int COMPAT_N = 16,
  parameter int VEC_W    = $clog2(NUM_MBX)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_MBX-1:0] pend,
  input  logic               compat_mode,
  output logic               gmif_q,
  output logic [VEC_W-1:0]   vec_q
);
  logic [VEC_W-1:0]   hi;
  logic               any;
  logic               in_range;
  logic [NUM_MBX-1:0] pend_d;

  always_comb begin
    hi = '0;
    for (int i = 0; i < NUM_MBX; i++) begin
      if (pend[i]) hi = VEC_W'(i);
    end
  end

  assign any      = |pend;
  assign in_range = !compat_mode || (int'(vec_q) < COMPAT_N);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gmif_q <= 1'b0;
      vec_q  <= '0;
      pend_d <= '0;
    end else begin
      gmif_q <= any;
      pend_d <= pend;
      if (!any)                                  vec_q <= '0;
      else if (!gmif_q || hi > vec_q || !in_range) vec_q <= hi;
    end
  end

  // R3: on a fresh flag the vector names the top pending mailbox
  p_vec_hi_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && gmif_q && !$past(gmif_q) |-> (pend_d >> vec_q) == NUM_MBX'(1));

  // R3: while the flag holds and the mode is steady the vector never falls
  p_vec_mono_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(gmif_q) && gmif_q && !$past(compat_mode) && !$past(compat_mode, 2)
    |-> vec_q >= $past(vec_q));

  // R4: nothing pending gives a zero vector and a cleared flag
  p_vec_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && !$past(any) |-> vec_q == '0 && !gmif_q);

  // R5: compatibility mode keeps the vector inside the reduced window
  p_vec_compat_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(compat_mode) |-> int'(vec_q) < COMPAT_N);
endmodule

// File: rtl/can_irq_sticky.sv
module can_irq_sticky #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set,
  input  logic [W-1:0] clr,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= (q & ~clr) | set;
  end

  // R8: a set in the previous clock is visible, whatever the clear did
  p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ((q & $past(set)) == $past(set)));

  // R8: a clear with no set empties the bit
  p_w1c_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ((q & $past(clr & ~set)) == '0));

  // R8: bits that see neither set nor clear keep their value
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (((q ^ $past(q)) & $past(~set & ~clr)) == '0));
endmodule

// File: rtl/can_irq_agg.sv
module can_irq_agg
  import can_irq_pkg::*;
#(
  parameter int NUM_MBX  = 32,
  parameter int COMPAT_N = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               compat_mode,
  input  logic [NUM_MBX-1:0] mbx_done,
  input  logic [NUM_MBX-1:0] mbx_tmo,
  input  logic [NUM_MBX-1:0] mbx_abort,
  input  logic [NUM_MBX-1:0] mbx_lost,
  input  logic [NUM_MBX-1:0] mbx_mask,
  input  logic [NUM_MBX-1:0] mbx_lvl,
  input  logic               glb_lvl,
  input  logic               ev_warn,
  input  logic               ev_epass,
  input  logic               ev_busoff,
  input  logic               ev_wake,
  input  logic               ev_wrdeny,
  input  logic               ts_msb,
  input  logic               clr_we,
  input  logic               clr_line,
  input  logic [FLAG_W-1:0]  clr_mask,
  output logic [FLAG_W-1:0]  flags0,
  output logic [FLAG_W-1:0]  flags1,
  output logic               irq0,
  output logic               irq1
);
  localparam int VEC_W = $clog2(NUM_MBX);

  logic              ts_q;
  logic              ts_rise;
  logic [N_EVT-1:0]  evt;
  logic [N_EVT-1:0]  clr_pick;
  logic [FLAG_W-1:0] flg_w [2];
  logic              irq_w [2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ts_q <= 1'b0;
    else        ts_q <= ts_msb;
  end
  assign ts_rise = ts_msb & ~ts_q;

  always_comb begin
    evt              = '0;
    evt[E_WARN]      = ev_warn;
    evt[E_EPASS]     = ev_epass;
    evt[E_BUSOFF]    = ev_busoff;
    evt[E_WAKE]      = ev_wake;
    evt[E_WRDENY]    = ev_wrdeny;
    evt[E_TSOVF]     = ts_rise;
    clr_pick           = '0;
    clr_pick[E_WARN]   = clr_mask[B_WARN];
    clr_pick[E_EPASS]  = clr_mask[B_EPASS];
    clr_pick[E_BUSOFF] = clr_mask[B_BUSOFF];
    clr_pick[E_WAKE]   = clr_mask[B_WAKE];
    clr_pick[E_WRDENY] = clr_mask[B_WRDENY];
    clr_pick[E_TSOVF]  = clr_mask[B_TSOVF];
  end

  for (genvar l = 0; l < 2; l++) begin : g_line
    localparam bit L1 = (l == 1);
    logic [NUM_MBX-1:0] pend;
    logic               tmo_c, ab_c, lost_c;
    logic               tmo_q, ab_q, lost_q;
    logic               gmif;
    logic [VEC_W-1:0]   vec;
    logic [N_EVT-1:0]   set_v, clr_v, stk;
    logic [FLAG_W-1:0]  fw;

    can_irq_route #(.NUM_MBX(NUM_MBX), .COMPAT_N(COMPAT_N), .LINE(L1)) u_route (
      .mbx_done(mbx_done), .mbx_tmo(mbx_tmo), .mbx_abort(mbx_abort),
      .mbx_lost(mbx_lost), .mbx_mask(mbx_mask), .mbx_lvl(mbx_lvl),
      .compat_mode(compat_mode), .pend(pend),
      .tmo_any(tmo_c), .abort_any(ab_c), .lost_any(lost_c)
    );

    can_irq_vec #(.NUM_MBX(NUM_MBX), .COMPAT_N(COMPAT_N), .VEC_W(VEC_W)) u_vec (
      .clk(clk), .rst_n(rst_n), .pend(pend), .compat_mode(compat_mode),
      .gmif_q(gmif), .vec_q(vec)
    );

    assign set_v = (glb_lvl == L1) ? evt : '0;
    assign clr_v = (clr_we && (clr_line == L1)) ? clr_pick : '0;

    can_irq_sticky #(.W(N_EVT)) u_stk (
      .clk(clk), .rst_n(rst_n), .set(set_v), .clr(clr_v), .q(stk)
    );

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        tmo_q  <= 1'b0;
        ab_q   <= 1'b0;
        lost_q <= 1'b0;
      end else begin
        tmo_q  <= tmo_c;
        ab_q   <= ab_c;
        lost_q <= lost_c;
      end
    end

    always_comb begin
      fw             = '0;
      fw[VEC_W-1:0]  = vec;
      fw[B_TMO]      = tmo_q;
      fw[B_GMIF]     = gmif;
      fw[B_ABORT]    = ab_q;
      fw[B_LOST]     = lost_q;
      fw[B_WARN]     = stk[E_WARN];
      fw[B_EPASS]    = stk[E_EPASS];
      fw[B_BUSOFF]   = stk[E_BUSOFF];
      fw[B_WAKE]     = stk[E_WAKE];
      fw[B_WRDENY]   = stk[E_WRDENY];
      fw[B_TSOVF]    = stk[E_TSOVF];
    end

    assign flg_w[l] = fw;
    assign irq_w[l] = |fw[B_TMO:B_WARN];

    // R1 with R2 routing: an enabled done mailbox on this line raises the flag
    p_gmif_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) && !$past(compat_mode) &&
      $past(|(mbx_done & mbx_mask & (L1 ? mbx_lvl : ~mbx_lvl))) |-> flg_w[l][B_GMIF]);

    // R5: timeout flag is held low in compatibility mode
    p_tmo_compat_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) && $past(compat_mode) |-> !flg_w[l][B_TMO]);

    // R6: a rising timestamp MSB on the selected line sets overflow
    p_tsovf_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) && $past(ts_msb) && !$past(ts_msb, 2) && ($past(glb_lvl) == L1)
      |-> flg_w[l][B_TSOVF]);
  end

  assign flags0 = flg_w[0];
  assign flags1 = flg_w[1];
  assign irq0   = irq_w[0];
  assign irq1   = irq_w[1];
endmodule

// File: tb/can_irq_agg_tb.sv
module can_irq_agg_tb_top;
  localparam int N = 32;
  localparam logic [31:0] STK_M = 32'h0001_3700; // bits 16,13,12,10,9,8
  localparam logic [31:0] RSV_M = 32'hFFFC_00E0; // bits 31:18, 7:5

  logic clk = 1'b0, rst_n = 1'b0;
  logic compat_mode = 1'b0;
  logic [N-1:0] mbx_done = '0, mbx_tmo = '0, mbx_abort = '0, mbx_lost = '0;
  logic [N-1:0] mbx_mask = '1, mbx_lvl = '0;
  logic glb_lvl = 1'b0, ev_warn = 1'b0, ev_epass = 1'b0, ev_busoff = 1'b0;
  logic ev_wake = 1'b0, ev_wrdeny = 1'b0, ts_msb = 1'b0;
  logic clr_we = 1'b0, clr_line = 1'b0;
  logic [31:0] clr_mask = '0;
  logic [31:0] flags0, flags1;
  logic irq0, irq1;

  int n_chk = 0, n_err = 0, cyc_cnt = 0;
  logic [31:0] exp_stk [2];
  logic [4:0]  exp_vec [2];
  logic        exp_gm  [2];
  logic [31:0] exp_w   [2];
  logic        ts_prev;

  can_irq_agg #(.NUM_MBX(N), .COMPAT_N(16)) dut_i (
    .clk(clk), .rst_n(rst_n), .compat_mode(compat_mode),
    .mbx_done(mbx_done), .mbx_tmo(mbx_tmo), .mbx_abort(mbx_abort),
    .mbx_lost(mbx_lost), .mbx_mask(mbx_mask), .mbx_lvl(mbx_lvl),
    .glb_lvl(glb_lvl), .ev_warn(ev_warn), .ev_epass(ev_epass),
    .ev_busoff(ev_busoff), .ev_wake(ev_wake), .ev_wrdeny(ev_wrdeny),
    .ts_msb(ts_msb), .clr_we(clr_we), .clr_line(clr_line), .clr_mask(clr_mask),
    .flags0(flags0), .flags1(flags1), .irq0(irq0), .irq1(irq1)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cyc_cnt++;
    if (cyc_cnt > 150000) begin
      n_err++;
      $display("FAIL watchdog: run did not complete");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic model_step();
    logic [31:0] mk, rt, pend, stk, w;
    logic tmo, ab, lo;
    int hi;
    mk = compat_mode ? 32'h0000_FFFF : 32'hFFFF_FFFF;
    for (int l = 0; l < 2; l++) begin
      rt   = (l == 1) ? mbx_lvl : ~mbx_lvl;
      pend = mbx_done & mbx_mask & rt & mk;
      tmo  = !compat_mode && |(mbx_tmo & rt & mk);
      ab   = |(mbx_abort & rt & mk);
      lo   = |(mbx_lost & rt & mk);
      hi = 0;
      for (int i = 0; i < N; i++) if (pend[i]) hi = i;
      stk = exp_stk[l];
      if (clr_we && (int'(clr_line) == l)) stk = stk & ~clr_mask;
      if (int'(glb_lvl) == l) begin
        stk[8]  = stk[8]  | ev_warn;
        stk[9]  = stk[9]  | ev_epass;
        stk[10] = stk[10] | ev_busoff;
        stk[12] = stk[12] | ev_wake;
        stk[13] = stk[13] | ev_wrdeny;
        stk[16] = stk[16] | (ts_msb & ~ts_prev);
      end
      stk = stk & STK_M;
      if (pend == 0) exp_vec[l] = 5'd0;
      else if (!exp_gm[l] || hi > int'(exp_vec[l]) || (compat_mode && exp_vec[l] >= 5'd16))
        exp_vec[l] = 5'(hi);
      exp_gm[l]  = (pend != 0);
      exp_stk[l] = stk;
      w = stk;
      w[4:0] = exp_vec[l];
      w[15] = exp_gm[l];
      w[17] = tmo;
      w[14] = ab;
      w[11] = lo;
      exp_w[l] = w;
    end
    ts_prev = ts_msb;
  endtask

  // one clock: model, edge, compare every field, back to falling edge
  task automatic cyc();
    logic [31:0] act;
    model_step();
    @(posedge clk);
    #2;
    for (int l = 0; l < 2; l++) begin
      act = (l == 1) ? flags1 : flags0;
      chk("R1", "mailbox flag", act & 32'h8000, exp_w[l] & 32'h8000);
      chk("R3", "vector", act & 32'h1F, exp_w[l] & 32'h1F);
      chk("R7", "status flags", act & 32'h2_4800, exp_w[l] & 32'h2_4800);
      chk("R8", "sticky flags", act & STK_M, exp_w[l] & STK_M);
      chk("R9", "reserved bits", act & RSV_M, 32'h0);
      chk("R10", "irq line", {31'b0, (l == 1) ? irq1 : irq0}, {31'b0, |exp_w[l][17:8]});
    end
    @(negedge clk);
  endtask

  task automatic quiet();
    mbx_done = '0; mbx_tmo = '0; mbx_abort = '0; mbx_lost = '0;
    mbx_mask = '1; mbx_lvl = '0; compat_mode = 1'b0; glb_lvl = 1'b0;
    ev_warn = 1'b0; ev_epass = 1'b0; ev_busoff = 1'b0; ev_wake = 1'b0;
    ev_wrdeny = 1'b0; clr_we = 1'b0; clr_line = 1'b0; clr_mask = '0;
  endtask

  initial begin
    void'($urandom(32'd24681));
    for (int l = 0; l < 2; l++) begin
      exp_stk[l] = '0; exp_vec[l] = '0; exp_gm[l] = 1'b0; exp_w[l] = '0;
    end
    ts_prev = 1'b0;
    repeat (3) @(negedge clk);
    // R11: reset state
    chk("R11", "flags0 in reset", flags0, 32'h0);
    chk("R11", "flags1 in reset", flags1, 32'h0);
    chk("R11", "irq in reset", {30'b0, irq1, irq0}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // R3/R4: sticky priority vector on line 0
    quiet(); mbx_done = (32'h1 << 5) | (32'h1 << 20); cyc();
    chk("R3", "vec picks 20", {27'b0, flags0[4:0]}, 32'd20);
    mbx_done = 32'h1 << 5; cyc();
    chk("R4", "vec held at 20", {27'b0, flags0[4:0]}, 32'd20);
    mbx_done = (32'h1 << 5) | (32'h1 << 25); cyc();
    chk("R3", "vec rises to 25", {27'b0, flags0[4:0]}, 32'd25);
    mbx_done = mbx_done | (32'h1 << 31) ; cyc();
    chk("R3", "vec top mailbox 31", {27'b0, flags0[4:0]}, 32'd31);
    mbx_done = '0; cyc();
    chk("R4", "vec and flag drop", flags0 & 32'h801F, 32'h0);

    // R1: masked-off mailbox raises nothing
    mbx_done = 32'h1 << 9; mbx_mask = ~(32'h1 << 9); cyc();
    chk("R1", "masked done ignored", {31'b0, flags0[15]}, 32'h0);

    // R2: mailbox 7 routed to line 1
    quiet(); mbx_lvl = 32'h1 << 7; mbx_done = 32'h1 << 7; mbx_abort = 32'h1 << 7; cyc();
    chk("R2", "line1 gets mailbox 7", {27'b0, flags1[4:0]} | {16'b0, flags1[15], 15'b0}, 32'h0000_8007);
    chk("R2", "line0 untouched", flags0 & 32'h0002_C81F, 32'h0);
    chk("R2", "abort on line1", {31'b0, flags1[14]}, 32'h1);

    // R7: write-1-to-clear leaves status flags alone
    clr_we = 1'b1; clr_line = 1'b1; clr_mask = '1; cyc();
    chk("R7", "abort survives clear", {31'b0, flags1[14]}, 32'h1);
    chk("R9", "reserved after clear all", flags1 & RSV_M, 32'h0);
    quiet(); cyc();
    chk("R7", "abort drops with source", {31'b0, flags1[14]}, 32'h0);

    // R5: compatibility window
    quiet(); mbx_done = 32'h1 << 30; cyc();
    compat_mode = 1'b1; mbx_done = (32'h1 << 30) | (32'h1 << 9); mbx_tmo = '1; cyc();
    chk("R5", "vec reselected to 9", {27'b0, flags0[4:0]}, 32'd9);
    chk("R5", "timeout forced low", {31'b0, flags0[17]}, 32'h0);
    mbx_done = 32'h1 << 16; cyc();
    chk("R5", "mailbox 16 ignored", {31'b0, flags0[15]}, 32'h0);

    // R6: timestamp MSB edge
    quiet(); ts_msb = 1'b1; cyc();
    chk("R6", "overflow on rise", {31'b0, flags0[16]}, 32'h1);
    clr_we = 1'b1; clr_mask = 32'h1 << 16; cyc();
    clr_we = 1'b0; cyc();
    chk("R6", "high level no re-set", {31'b0, flags0[16]}, 32'h0);
    ts_msb = 1'b0; cyc();

    // R8: sticky events, routing, clear rules
    quiet(); glb_lvl = 1'b1; ev_busoff = 1'b1; cyc();
    ev_busoff = 1'b0; cyc();
    chk("R8", "busoff sticky on line1", {31'b0, flags1[10]}, 32'h1);
    chk("R8", "busoff not on line0", {31'b0, flags0[10]}, 32'h0);
    clr_we = 1'b1; clr_line = 1'b1; clr_mask = ~(32'h1 << 10); cyc();
    chk("R8", "zero mask keeps busoff", {31'b0, flags1[10]}, 32'h1);
    clr_line = 1'b0; clr_mask = '1; cyc();
    chk("R8", "other-line clear ignored", {31'b0, flags1[10]}, 32'h1);
    clr_line = 1'b1; clr_mask = 32'h1 << 10; cyc();
    chk("R8", "busoff cleared", {31'b0, flags1[10]}, 32'h0);
    clr_mask = 32'h1 << 8; ev_warn = 1'b1; cyc();
    chk("R8", "set wins over clear", {31'b0, flags1[8]}, 32'h1);
    chk("R10", "irq1 high", {31'b0, irq1}, 32'h1);

    // random traffic against the model
    for (int k = 0; k < 3000; k++) begin
      mbx_done  = ($urandom % 4 == 0) ? '0 : ($urandom & $urandom & $urandom);
      mbx_mask  = $urandom | $urandom;
      mbx_lvl   = ($urandom % 8 == 0) ? $urandom : mbx_lvl;
      mbx_tmo   = $urandom & $urandom & $urandom & $urandom;
      mbx_abort = $urandom & $urandom & $urandom & $urandom;
      mbx_lost  = $urandom & $urandom & $urandom & $urandom;
      compat_mode = ($urandom % 6 == 0);
      glb_lvl   = $urandom % 2;
      ev_warn   = ($urandom % 16 == 0);
      ev_epass  = ($urandom % 16 == 0);
      ev_busoff = ($urandom % 16 == 0);
      ev_wake   = ($urandom % 16 == 0);
      ev_wrdeny = ($urandom % 16 == 0);
      ts_msb    = ($urandom % 4 == 0) ? ~ts_msb : ts_msb;
      clr_we    = ($urandom % 4 == 0);
      clr_line  = $urandom % 2;
      clr_mask  = $urandom;
      cyc();
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule